// File: doc/BRIEF.md
# Manual-Mode Serial Word Aligner

This block sits behind a deserializer whose parallel words start at an arbitrary bit of the serial stream. It keeps the newest two parallel words side by side and, in every cycle, compares a programmable alignment pattern against each of the W possible starting bits in parallel. While a search is armed, the first cycle in which the pattern shows up fixes the word boundary. From then on every output word starts on that boundary, and a sticky sync flag reports the lock.

Three modes are selected by a static input. In manual mode, a new search starts only on a rising edge of the align request. In bitslip mode the request is ignored, and each change of level on the slip input moves the boundary by one bit. In bypass mode the raw words pass straight through. The output stage can mirror the bit order of each word. When the word width is 16 or 20 it can also exchange the two halves of the word.

Top module: `word_aligner`

## Requirements
- R1: Serial order within a word is bit 0 first. The word sampled at edge n is the newer word and the word sampled at edge n-1 is the older one. With the boundary at offset k, the word presented after edge n is bits k..k+W-1 of {newer, older}, where the older word occupies the low W bits.
- R2: After reset, or after a manual re-arm, the first edge at which some offset k has bits k..k+PAT_LEN-1 of {newer, older} equal to the pattern locks the boundary at the lowest such k. The word presented after that same edge is already aligned, and sync rises after that edge. PAT_LEN is a parameter, and lengths 7 and 10 are supported.
- R3: Once locked in manual mode, sync stays high and the offset stays fixed until a rising edge of the align request, even when the pattern later appears at another offset.
- R4: In manual mode, an align request sampled high at one edge and low at the previous edge clears sync after that edge and re-arms the search. A lock never happens on that same edge. Holding the request high does not re-arm the search again.
- R5: Pattern detect is high after an edge exactly when the low PAT_LEN bits of the word presented after that edge, taken before reversal, equal the pattern.
- R6: Mode 1 (bitslip): an edge at which the slip input differs from its previous level advances the offset by one, wrapping from W-1 to 0. The word presented after that edge already uses the new offset, and sync keeps its value.
- R7: In bitslip mode the align request has no effect on sync or on the offset.
- R8: Mode 2 or 3 (bypass): the word presented after edge n is the word sampled at edge n-1. The stored offset and sync are left unchanged.
- R9: With bit reversal enabled, output bit i is taken from bit W-1-i of the selected word, in every mode. For example, 1000010011 becomes 1100100001. Pattern matching always uses the unreversed bits.
- R10: With the half swap enabled and W equal to 16 or 20, the low and high halves of the word are exchanged after any bit reversal. At any other width the swap control has no effect.
- R11: A synchronous active-high reset clears the output word, sync, pattern detect and the offset, and arms a search. Mode 0 is manual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | 0 manual, 1 bitslip, 2 or 3 bypass |
| pattern | input | PAT_LEN | Alignment pattern, bit 0 first in serial order |
| align_req | input | 1 | Re-alignment request, acts on its rising edge |
| bitslip | input | 1 | Boundary step, acts on each level change |
| rev_bits | input | 1 | Mirror the bit order of the output word |
| swap_bytes | input | 1 | Exchange the word halves (W of 16 or 20 only) |
| din | input | W | Unaligned word from the deserializer |
| dout | output | W | Aligned word |
| sync_status | output | 1 | Sticky boundary-locked flag |
| pat_det | output | 1 | Pattern present on the current boundary |

## Verification
A wrong stored offset shows up in the very next output word as a rotated mix of two input words, two edges after those words entered. A search flag left armed after lock becomes visible when a later pattern at another offset moves the boundary. A search flag that is never armed shows as sync staying low. A stale request-edge register shows up as sync dropping while the request is held high, or as sync failing to drop on a fresh edge. A wrong slip step or a wrong wrap appears in the word that follows the slip edge.

// File: rtl/wa_pkg.sv
package wa_pkg;

    typedef enum logic [1:0] {
        WA_MANUAL     = 2'd0,
        WA_SLIP       = 2'd1,
        WA_BYPASS     = 2'd2,
        WA_BYPASS_ALT = 2'd3
    } wa_mode_e;

endpackage

// File: rtl/wa_match_bank.sv
module wa_match_bank #(
    parameter int W       = 10,
    parameter int PAT_LEN = 7
) (
    input  logic [2*W-1:0]     pair,
    input  logic [PAT_LEN-1:0] pattern,
    output logic [W-1:0]       hit
);

    // one comparator per candidate boundary
    for (genvar k = 0; k < W; k++) begin : g_cmp
        assign hit[k] = (pair[k +: PAT_LEN] == pattern);
    end

endmodule

// File: rtl/wa_lowest_hit.sv
module wa_lowest_hit #(
    parameter int W  = 10,
    parameter int OW = 4
) (
    input  logic [W-1:0]  hit,
    output logic          found,
    output logic [OW-1:0] idx
);

    always_comb begin
        found = |hit;
        idx   = '0;
        for (int k = W - 1; k >= 0; k--) begin
            if (hit[k]) begin
                idx = OW'(k);
            end
        end
    end

endmodule

// File: rtl/wa_out_stage.sv
module wa_out_stage #(
    parameter int W = 10
) (
    input  logic [W-1:0] win,
    input  logic         rev_en,
    input  logic         swap_en,
    output logic [W-1:0] word
);

    localparam int  HALF    = W / 2;
    localparam bit  SWAP_OK = (W == 16) || (W == 20);

    logic [W-1:0] mirrored;
    logic [W-1:0] ordered;
    logic [W-1:0] swapped;

    for (genvar i = 0; i < W; i++) begin : g_mirror
        assign mirrored[i] = win[W-1-i];
    end

    assign ordered = rev_en ? mirrored : win;
    assign swapped = {ordered[HALF-1:0], ordered[W-1:HALF]};
    assign word    = (swap_en && SWAP_OK) ? swapped : ordered;

endmodule

// File: rtl/word_aligner.sv
module word_aligner
    import wa_pkg::*;
#(
    parameter int W       = 10,
    parameter int PAT_LEN = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         mode,
    input  logic [PAT_LEN-1:0] pattern,
    input  logic               align_req,
    input  logic               bitslip,
    input  logic               rev_bits,
    input  logic               swap_bytes,
    input  logic [W-1:0]       din,
    output logic [W-1:0]       dout,
    output logic               sync_status,
    output logic               pat_det
);

    localparam int OW = $clog2(W);

    typedef struct packed {
        logic [W-1:0]  held;
        logic          req;
        logic          slip;
        logic [OW-1:0] off;
        logic          armed;
        logic          sync;
        logic [W-1:0]  word;
        logic          det;
    } st_t;

    localparam st_t ST_RST = '{
        held:  '0,
        req:   1'b0,
        slip:  1'b0,
        off:   '0,
        armed: 1'b1,
        sync:  1'b0,
        word:  '0,
        det:   1'b0
    };

    st_t st_d, st_q;

    wa_mode_e      mode_e;
    logic [2*W-1:0] pair;
    logic [W-1:0]  hit;
    logic          found;
    logic [OW-1:0] lo_idx;
    logic          rise;
    logic          toggle;
    logic          lock;
    logic [OW-1:0] off_step;
    logic [OW-1:0] off_eff;
    logic [W-1:0]  win;
    logic [W-1:0]  out_word;

    assign mode_e = wa_mode_e'(mode);

    // older word in the low half, newer word on top
    assign pair = {din, st_q.held};

    wa_match_bank #(.W(W), .PAT_LEN(PAT_LEN)) u_match (
        .pair    (pair),
        .pattern (pattern),
        .hit     (hit)
    );

    wa_lowest_hit #(.W(W), .OW(OW)) u_pick (
        .hit   (hit),
        .found (found),
        .idx   (lo_idx)
    );

    assign rise     = align_req & ~st_q.req;
    assign toggle   = bitslip ^ st_q.slip;
    assign off_step = (st_q.off == OW'(W - 1)) ? '0 : st_q.off + 1'b1;
    assign lock     = (mode_e == WA_MANUAL) && !rise && st_q.armed && found;

    // boundary used for the word leaving this cycle
    assign off_eff = mode[1]                           ? '0       :
                     ((mode_e == WA_SLIP) && toggle)   ? off_step :
                     lock                              ? lo_idx   :
                                                         st_q.off;

    assign win = W'(pair >> off_eff);

    wa_out_stage #(.W(W)) u_out (
        .win     (win),
        .rev_en  (rev_bits),
        .swap_en (swap_bytes),
        .word    (out_word)
    );

    always_comb begin
        st_d      = st_q;
        st_d.held = din;
        st_d.req  = align_req;
        st_d.slip = bitslip;
        st_d.word = out_word;
        st_d.det  = hit[off_eff];

        if (!mode[1]) begin
            st_d.off = off_eff;
        end

        if (mode_e == WA_MANUAL) begin
            if (rise) begin
                st_d.armed = 1'b1;
                st_d.sync  = 1'b0;
            end else if (lock) begin
                st_d.armed = 1'b0;
                st_d.sync  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout        = st_q.word;
    assign sync_status = st_q.sync;
    assign pat_det     = st_q.det;

endmodule

// File: rtl/wa_checker.sv
module wa_checker #(
    parameter int W = 10
) (
    input logic                   clk,
    input logic                   rst,
    input logic [1:0]             mode,
    input logic                   align_req,
    input logic                   bitslip,
    input logic                   req_q,
    input logic                   slip_q,
    input logic [$clog2(W)-1:0]   off_q,
    input logic                   armed_q,
    input logic                   sync_status
);

    localparam int OW = $clog2(W);

    logic manual_rise;
    assign manual_rise = (mode == 2'd0) && align_req && !req_q;

    p_rise_clears_sync_r4: assert property (@(posedge clk) disable iff (rst)
        manual_rise |=> !sync_status);

    p_sync_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (sync_status && !manual_rise) |=> sync_status);

    p_locked_offset_r3: assert property (@(posedge clk) disable iff (rst)
        ((mode == 2'd0) && !armed_q) |=> $stable(off_q));

    p_slip_step_r6: assert property (@(posedge clk) disable iff (rst)
        ((mode == 2'd1) && (bitslip != slip_q)) |=>
            (off_q == (($past(off_q) == OW'(W - 1)) ? '0 : $past(off_q) + 1'b1)));

    p_slip_keeps_sync_r7: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd1) |=> $stable(sync_status));

    p_bypass_holds_r8: assert property (@(posedge clk) disable iff (rst)
        mode[1] |=> ($stable(off_q) && $stable(sync_status)));

endmodule

bind word_aligner wa_checker #(.W(W)) u_wa_chk (
    .clk         (clk),
    .rst         (rst),
    .mode        (mode),
    .align_req   (align_req),
    .bitslip     (bitslip),
    .req_q       (st_q.req),
    .slip_q      (st_q.slip),
    .off_q       (st_q.off),
    .armed_q     (st_q.armed),
    .sync_status (sync_status)
);

// File: tb/word_aligner_bench.sv
module word_aligner_bench;

    localparam int W   = 10;
    localparam int PL  = 7;
    localparam int W2  = 20;
    localparam int PL2 = 10;
    localparam logic [PL-1:0] PAT = 7'b1010011;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst;
    logic [1:0]    mode;
    logic [PL-1:0] pattern;
    logic          align_req, bitslip, rev_bits, swap_bytes;
    logic [W-1:0]  din, dout;
    logic          sync_status, pat_det;

    logic [W2-1:0] din2, dout2;
    logic          rev2, swap2, sync2, det2;

    word_aligner #(.W(W), .PAT_LEN(PL)) u_word_aligner (
        .clk(clk), .rst(rst), .mode(mode), .pattern(pattern),
        .align_req(align_req), .bitslip(bitslip), .rev_bits(rev_bits),
        .swap_bytes(swap_bytes), .din(din), .dout(dout),
        .sync_status(sync_status), .pat_det(pat_det)
    );

    word_aligner #(.W(W2), .PAT_LEN(PL2)) u_word_aligner_w20 (
        .clk(clk), .rst(rst), .mode(2'd2), .pattern(10'h155),
        .align_req(1'b0), .bitslip(1'b0), .rev_bits(rev2),
        .swap_bytes(swap2), .din(din2), .dout(dout2),
        .sync_status(sync2), .pat_det(det2)
    );

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] lastw;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [W-1:0] win10(input logic [W-1:0] newer, input logic [W-1:0] older, input int k);
        logic [2*W-1:0] c;
        c = {newer, older};
        return c[k +: W];
    endfunction

    function automatic logic [W-1:0] rev10(input logic [W-1:0] x);
        logic [W-1:0] y;
        for (int i = 0; i < W; i++) y[i] = x[W-1-i];
        return y;
    endfunction

    function automatic logic [W2-1:0] rev20(input logic [W2-1:0] x);
        logic [W2-1:0] y;
        for (int i = 0; i < W2; i++) y[i] = x[W2-1-i];
        return y;
    endfunction

    task automatic do_reset;
        rst = 1'b1; mode = 2'd0; align_req = 1'b0; bitslip = 1'b0;
        rev_bits = 1'b0; swap_bytes = 1'b0; din = '0; din2 = '0;
        rev2 = 1'b0; swap2 = 1'b0; pattern = PAT;
        tick; tick;
        rst = 1'b0;
        lastw = '0;
    endtask

    task automatic feed(input logic [W-1:0] w);
        din = w;
        tick;
        lastw = w;
    endtask

    // pattern placed at stream bit W+p, zero filler elsewhere
    task automatic lock_at(input int p, input logic r);
        logic [3*W-1:0] s;
        logic [W-1:0]   e;
        s = '0;
        s[W+p +: PL] = PAT;
        do_reset;
        rev_bits = r;
        feed(s[0 +: W]);
        feed(s[W +: W]);
        chk("R2 no lock before pattern", {31'd0, sync_status}, 32'd0);
        feed(s[2*W +: W]);
        e = r ? rev10(W'(PAT)) : W'(PAT);
        chk($sformatf("R2 aligned word p=%0d", p), 32'(dout), 32'(e));
        chk("R2 sync after lock", {31'd0, sync_status}, 32'd1);
        chk("R5 detect on aligned pattern", {31'd0, pat_det}, 32'd1);
        feed('0);
        chk("R5 detect clears", {31'd0, pat_det}, 32'd0);
        chk("R3 sync held", {31'd0, sync_status}, 32'd1);
        chk("R1 zero window", 32'(dout), 32'd0);
        rev_bits = 1'b0;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [3*W-1:0] s;
        logic [W-1:0]   w, e;
        logic [W2-1:0]  x, y;
        int o;

        // R11 reset state
        do_reset;
        chk("R11 reset dout", 32'(dout), 32'd0);
        chk("R11 reset sync", {31'd0, sync_status}, 32'd0);
        chk("R11 reset detect", {31'd0, pat_det}, 32'd0);

        // R1 R2 R9: sweep every boundary, reversal on odd offsets
        for (int p = 0; p < W; p++) lock_at(p, p[0]);

        // R2 lowest offset wins
        do_reset;
        s = '0;
        s[W+2 +: PL] = PAT;
        s[W+8 +: PL] = s[W+8 +: PL] | PAT;
        feed(s[0 +: W]); feed(s[W +: W]); feed(s[2*W +: W]);
        chk("R2 lowest offset", 32'(dout), 32'(win10(s[2*W +: W], s[W +: W], 2)));
        chk("R2 lowest offset detect", {31'd0, pat_det}, 32'd1);

        // R3 later pattern elsewhere does not move the boundary
        lock_at(3, 1'b0);
        s = '0;
        s[W+6 +: PL] = PAT;
        feed(s[0 +: W]); feed(s[W +: W]);
        chk("R1 window at offset 3", 32'(dout), 32'(win10(s[W +: W], s[0 +: W], 3)));
        feed(s[2*W +: W]);
        e = win10(s[2*W +: W], s[W +: W], 3);
        chk("R3 offset kept", 32'(dout), 32'(e));
        chk("R5 detect follows window", {31'd0, pat_det}, {31'd0, e[PL-1:0] == PAT});
        chk("R3 sync kept", {31'd0, sync_status}, 32'd1);

        // R4 rising request re-arms
        align_req = 1'b1;
        feed('0);
        chk("R4 sync cleared", {31'd0, sync_status}, 32'd0);
        feed(s[0 +: W]); feed(s[W +: W]); feed(s[2*W +: W]);
        chk("R4 relock sync", {31'd0, sync_status}, 32'd1);
        chk("R4 relock offset 6", 32'(dout), 32'(W'(PAT)));
        begin
            logic [3*W-1:0] t;
            t = '0;
            t[W+1 +: PL] = PAT;
            feed(t[0 +: W]); feed(t[W +: W]); feed(t[2*W +: W]);
            chk("R4 held request no rearm", 32'(dout), 32'(win10(t[2*W +: W], t[W +: W], 6)));
            chk("R4 held request sync", {31'd0, sync_status}, 32'd1);
        end
        align_req = 1'b0;
        feed(s[0 +: W]); feed(s[W +: W]);
        align_req = 1'b1;
        feed(s[2*W +: W]);
        chk("R4 no lock on rise edge", {31'd0, sync_status}, 32'd0);
        feed('0);
        chk("R4 stays low without pattern", {31'd0, sync_status}, 32'd0);
        align_req = 1'b0;

        // R6 bitslip steps with wrap
        lock_at(6, 1'b0);
        mode = 2'd1;
        o = 6;
        for (int n = 0; n < 12; n++) begin
            w = W'((n * 97 + 13) & 1023);
            bitslip = ~bitslip;
            e = win10(w, lastw, (o + 1) % W);
            feed(w);
            o = (o + 1) % W;
            chk($sformatf("R6 slip to offset %0d", o), 32'(dout), 32'(e));
            chk("R6 sync kept on slip", {31'd0, sync_status}, 32'd1);
        end
        w = 10'h1B7;
        e = win10(w, lastw, o);
        feed(w);
        chk("R6 no toggle no step", 32'(dout), 32'(e));

        // R7 request ignored in bitslip mode
        align_req = 1'b1;
        w = 10'h0E9;
        e = win10(w, lastw, o);
        feed(w);
        chk("R7 sync unaffected", {31'd0, sync_status}, 32'd1);
        chk("R7 offset unaffected", 32'(dout), 32'(e));
        chk("R7 detect from window", {31'd0, pat_det}, {31'd0, e[PL-1:0] == PAT});
        align_req = 1'b0;
        feed('0);

        // R8 bypass passes previous word
        mode = 2'd2;
        for (int n = 0; n < 6; n++) begin
            w = W'((n * 211 + 5) & 1023);
            e = lastw;
            feed(w);
            if (n > 0) chk("R8 bypass word", 32'(dout), 32'(e));
        end
        chk("R8 sync unchanged", {31'd0, sync_status}, 32'd1);
        mode = 2'd3;
        w = 10'h2A6;
        feed(w); feed('0);
        chk("R8 mode 3 bypass", 32'(dout), 32'(w));

        // R9 reversal example
        mode = 2'd2;
        rev_bits = 1'b1;
        feed(10'b1000010011); feed('0);
        chk("R9 reversal example", 32'(dout), 32'(10'b1100100001));

        // R10 swap has no effect at width 10
        swap_bytes = 1'b1;
        feed(10'h2C5); feed('0);
        chk("R10 swap ignored at W=10", 32'(dout), 32'(rev10(10'h2C5)));
        swap_bytes = 1'b0;
        rev_bits = 1'b0;

        // R10 width 20: all reversal and swap combinations
        for (int n = 0; n < 8; n++) begin
            rev2  = n[0];
            swap2 = n[1];
            x = W2'((n * 40503 + 777) & 20'hFFFFF);
            din2 = x;
            tick;
            din2 = '0;
            tick;
            y = rev2 ? rev20(x) : x;
            if (swap2) y = {y[9:0], y[19:10]};
            chk($sformatf("R10 width 20 rev=%0d swap=%0d", rev2, swap2), 32'(dout2), 32'(y));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule